// File: doc/BRIEF.md
# Fixed-Point Sprite Position Updater

This block holds the positions of a ball and a paddle on a 720 by 507 pixel playfield. The ball's two coordinates are kept in fixed point, with an 8-bit subpixel fraction below a 10-bit whole-pixel part. On every subframe tick, each coordinate moves by a signed velocity expressed in subpixels. A frame contains 256 subframe ticks, so a velocity of N subpixels per subframe is also N pixels per frame. The paddle moves only vertically, in whole pixels, and takes one step of its signed velocity on each frame tick.

When a ball step would leave the field on an axis, that coordinate is clamped to the edge and the velocity component on that axis changes sign, so the ball bounces. The paddle has no bounce. It is clamped so that its whole length stays inside the field height.

On each frame tick the block captures the whole-pixel parts of all three positions into output registers, which the renderer reads. The ticks and the velocity-load strobe are plain single-cycle control pulses. The outputs are level registers that change only on a frame tick, so there is no handshake and no back-pressure.

Top module: `sprite_pos_updater`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the ball at pixel (360, 253) with zero fraction and zero velocity on both axes, and puts the paddle at row 221. The three outputs read 360, 253 and 221.
- R2: When `subframe_tick` is high, each ball coordinate becomes its 18-bit fixed-point value (whole pixel times 256 plus fraction) plus its sign-extended two's-complement velocity. This applies whenever the result lies between 0 and the axis maximum. The axis maximum is 719×256 for horizontal and 506×256 for vertical.
- R3: If a ball step would give a value below 0, that coordinate becomes 0 and that velocity component is negated.
- R4: If a ball step would give a value above the axis maximum, that coordinate becomes the maximum and that velocity component is negated.
- R5: Without `subframe_tick`, the ball position and velocity do not change.
- R6: When `ball_vel_load` is high, both ball velocities take the values of `ball_vx_in` and `ball_vy_in`, with the code -256 stored as -255. The loaded value wins over a bounce in the same cycle. A step in that same cycle uses the old velocity.
- R7: When `frame_tick` is high, the paddle row becomes its old value plus the sign-extended `paddle_vel`, clamped to the range 0 to 443 (field height minus the 64-pixel paddle length).
- R8: Without `frame_tick`, the paddle row does not change.
- R9: The outputs change only on a `frame_tick` cycle. They then show the whole-pixel parts of the ball coordinates and the paddle row as they were before that cycle's updates.
- R10: A `frame_tick` together with a `subframe_tick` performs both updates in one cycle. The captured outputs are the values from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| subframe_tick | input | 1 | One-cycle pulse that advances the ball |
| frame_tick | input | 1 | One-cycle pulse that advances the paddle and refreshes the outputs |
| ball_vel_load | input | 1 | Load strobe for the ball velocities |
| ball_vx_in | input | 9 | Horizontal ball velocity, signed subpixels per subframe |
| ball_vy_in | input | 9 | Vertical ball velocity, signed subpixels per subframe |
| paddle_vel | input | 8 | Signed paddle velocity, pixels per frame |
| ball_x_px | output | 10 | Latched ball column |
| ball_y_px | output | 10 | Latched ball row |
| paddle_y_px | output | 10 | Latched paddle row |

## Verification
Directed runs are the base. The bench loads a single velocity and steps a known number of subframes, which separates correct carries from the fraction into the pixel part from a misaligned binary point. It drives the ball at full speed into each edge, which exposes a wrong clamp value, a missing sign flip, or a flip on the wrong axis. It also pushes the paddle past both of its limits.

Idle gaps with frame ticks but no subframe ticks, and the reverse, separate the two update clocks from each other. A load of -256 covers the one code whose negation overflows. A long constrained-random run with changing velocities, bounces and coincident ticks then compares every cycle against an arithmetic model, which catches errors in capture timing and in the old-versus-new value rules.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam int FIELD_W_DEF    = 720;
  localparam int FIELD_H_DEF    = 507;
  localparam int PADDLE_LEN_DEF = 64;

  // Saturating load helper: the most negative code cannot be negated safely.
  function automatic logic [15:0] vel_sat16(input logic [15:0] v, input int w);
    logic [15:0] min_code;
    min_code = 16'(1) << (w - 1);
    min_code = min_code | ~((16'(1) << w) - 16'(1));
    return (v == min_code) ? v + 16'(1) : v;
  endfunction
endpackage

// File: rtl/spu_ball_axis.sv
module spu_ball_axis #(
  parameter int          POS_W   = 18,
  parameter int          VEL_W   = 9,
  parameter int unsigned MAX_FIX = 184064,
  parameter int unsigned RST_FIX = 92160
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [VEL_W-1:0] vel_in,
  output logic [POS_W-1:0] pos_q
);
  localparam int SUM_W = POS_W + 2;
  localparam logic [SUM_W-1:0] MAX_S = SUM_W'(MAX_FIX);
  localparam logic [POS_W-1:0] MAX_P = POS_W'(MAX_FIX);
  localparam logic [VEL_W-1:0] MIN_V = {1'b1, {(VEL_W-1){1'b0}}};

  logic [VEL_W-1:0] vel_q;
  logic [SUM_W-1:0] sum;
  logic             under, over;
  logic [VEL_W-1:0] vel_load_val;

  // Binary points aligned: both operands carry the fraction in the low bits.
  assign sum   = {2'b00, pos_q} + {{(SUM_W-VEL_W){vel_q[VEL_W-1]}}, vel_q};
  assign under = sum[SUM_W-1];
  assign over  = !under && (sum > MAX_S);
  assign vel_load_val = (vel_in == MIN_V) ? MIN_V + VEL_W'(1) : vel_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= POS_W'(RST_FIX);
      vel_q <= '0;
    end else begin
      if (tick) begin
        if (under) begin
          pos_q <= '0;
          vel_q <= -vel_q;
        end else if (over) begin
          pos_q <= MAX_P;
          vel_q <= -vel_q;
        end else begin
          pos_q <= sum[POS_W-1:0];
        end
      end
      if (load) vel_q <= vel_load_val;
    end
  end

  AST_BALL_RANGE: assert property (@(posedge clk) disable iff (rst) pos_q <= MAX_P); // R4
  AST_BALL_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(pos_q)); // R5
  AST_VEL_HOLD: assert property (@(posedge clk) disable iff (rst) !tick && !load |=> $stable(vel_q)); // R5
  AST_VEL_FLIP: assert property (@(posedge clk) disable iff (rst)
    tick && !load |=> (vel_q == $past(vel_q)) || (vel_q == -$past(vel_q))); // R3
  AST_VEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    load && (vel_in != MIN_V) |=> vel_q == $past(vel_in)); // R6
endmodule

// File: rtl/spu_paddle.sv
module spu_paddle #(
  parameter int PIX_W   = 10,
  parameter int VEL_W   = 8,
  parameter int MAX_ROW = 443,
  parameter int RST_ROW = 221
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [VEL_W-1:0] vel,
  output logic [PIX_W-1:0] row_q
);
  localparam int SUM_W = PIX_W + 2;
  localparam logic [SUM_W-1:0] MAX_S = SUM_W'(MAX_ROW);
  localparam logic [PIX_W-1:0] MAX_P = PIX_W'(MAX_ROW);

  logic [SUM_W-1:0] sum;
  assign sum = {2'b00, row_q} + {{(SUM_W-VEL_W){vel[VEL_W-1]}}, vel};

  always_ff @(posedge clk) begin
    if (rst) row_q <= PIX_W'(RST_ROW);
    else if (tick) begin
      if (sum[SUM_W-1])     row_q <= '0;
      else if (sum > MAX_S) row_q <= MAX_P;
      else                  row_q <= sum[PIX_W-1:0];
    end
  end

  AST_PADDLE_RANGE: assert property (@(posedge clk) disable iff (rst) row_q <= MAX_P); // R7
  AST_PADDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(row_q)); // R8
endmodule

// File: rtl/sprite_pos_updater.sv
module sprite_pos_updater #(
  parameter int PIX_W      = 10,
  parameter int FRAC_W     = 8,
  parameter int VEL_W      = 9,
  parameter int PAD_VEL_W  = 8,
  parameter int FIELD_W    = spu_pkg::FIELD_W_DEF,
  parameter int FIELD_H    = spu_pkg::FIELD_H_DEF,
  parameter int PADDLE_LEN = spu_pkg::PADDLE_LEN_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 subframe_tick,
  input  logic                 frame_tick,
  input  logic                 ball_vel_load,
  input  logic [VEL_W-1:0]     ball_vx_in,
  input  logic [VEL_W-1:0]     ball_vy_in,
  input  logic [PAD_VEL_W-1:0] paddle_vel,
  output logic [PIX_W-1:0]     ball_x_px,
  output logic [PIX_W-1:0]     ball_y_px,
  output logic [PIX_W-1:0]     paddle_y_px
);
  localparam int POS_W   = PIX_W + FRAC_W;
  localparam int AXES    = 2;
  localparam int X_MAX   = (FIELD_W - 1) << FRAC_W;
  localparam int Y_MAX   = (FIELD_H - 1) << FRAC_W;
  localparam int X_RST   = (FIELD_W / 2) << FRAC_W;
  localparam int Y_RST   = (FIELD_H / 2) << FRAC_W;
  localparam int PAD_MAX = FIELD_H - PADDLE_LEN;
  localparam int PAD_RST = PAD_MAX / 2;

  logic [VEL_W-1:0] vin  [AXES];
  logic [POS_W-1:0] bpos [AXES];
  logic [PIX_W-1:0] bint [AXES];
  logic [PIX_W-1:0] pad_row;

  assign vin[0] = ball_vx_in;
  assign vin[1] = ball_vy_in;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    spu_ball_axis #(
      .POS_W  (POS_W),
      .VEL_W  (VEL_W),
      .MAX_FIX((a == 0) ? X_MAX : Y_MAX),
      .RST_FIX((a == 0) ? X_RST : Y_RST)
    ) u_axis (
      .clk   (clk),
      .rst   (rst),
      .tick  (subframe_tick),
      .load  (ball_vel_load),
      .vel_in(vin[a]),
      .pos_q (bpos[a])
    );
    assign bint[a] = bpos[a][POS_W-1:FRAC_W];
  end

  spu_paddle #(
    .PIX_W  (PIX_W),
    .VEL_W  (PAD_VEL_W),
    .MAX_ROW(PAD_MAX),
    .RST_ROW(PAD_RST)
  ) u_paddle (
    .clk  (clk),
    .rst  (rst),
    .tick (frame_tick),
    .vel  (paddle_vel),
    .row_q(pad_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ball_x_px   <= PIX_W'(X_RST >> FRAC_W);
      ball_y_px   <= PIX_W'(Y_RST >> FRAC_W);
      paddle_y_px <= PIX_W'(PAD_RST);
    end else if (frame_tick) begin
      ball_x_px   <= bint[0];
      ball_y_px   <= bint[1];
      paddle_y_px <= pad_row;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(ball_x_px) && $stable(ball_y_px) && $stable(paddle_y_px)); // R9
  AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> ball_x_px == $past(bint[0]) && ball_y_px == $past(bint[1])); // R10
  AST_PAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> paddle_y_px == $past(pad_row)); // R9
endmodule

// File: tb/sprite_pos_updater_tb.sv
module sprite_pos_updater_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       subframe_tick = 0, frame_tick = 0, ball_vel_load = 0;
  logic [8:0] ball_vx_in = '0, ball_vy_in = '0;
  logic [7:0] paddle_vel = '0;
  logic [9:0] ball_x_px, ball_y_px, paddle_y_px;

  int errors = 0, checks = 0;
  int mbx, mby, mvx, mvy, mpad, mox, moy, mop;
  int bvx, bvy, pv;
  localparam int XMAX = 719 * 256;
  localparam int YMAX = 506 * 256;
  localparam int PMAX = 443;

  always #2.5 clk = ~clk;

  sprite_pos_updater u_dut (
    .clk(clk), .rst(rst), .subframe_tick(subframe_tick), .frame_tick(frame_tick),
    .ball_vel_load(ball_vel_load), .ball_vx_in(ball_vx_in), .ball_vy_in(ball_vy_in),
    .paddle_vel(paddle_vel), .ball_x_px(ball_x_px), .ball_y_px(ball_y_px),
    .paddle_y_px(paddle_y_px)
  );

  function automatic void axis_step(inout int p, inout int v, input int mx);
    int s;
    s = p + v;
    if (s < 0) begin p = 0; v = -v; end
    else if (s > mx) begin p = mx; v = -v; end
    else p = s;
  endfunction

  function automatic int sat_load(input int v);
    return (v == -256) ? -255 : v;
  endfunction

  function automatic int pad_step(input int p, input int v);
    int s;
    s = p + v;
    if (s < 0) return 0;
    if (s > PMAX) return PMAX;
    return s;
  endfunction

  task automatic model_reset();
    mbx = 360 * 256; mby = 253 * 256; mvx = 0; mvy = 0; mpad = 221;
    mox = 360; moy = 253; mop = 221;
  endtask

  task automatic check(input string tag);
    checks++;
    if (ball_x_px !== 10'(mox) || ball_y_px !== 10'(moy) || paddle_y_px !== 10'(mop)) begin
      errors++;
      $display("FAIL %s: got x=%0d y=%0d pad=%0d expected x=%0d y=%0d pad=%0d",
               tag, ball_x_px, ball_y_px, paddle_y_px, mox, moy, mop);
    end
  endtask

  task automatic step(input bit sf, input bit fr, input bit ld, input string tag);
    @(negedge clk);
    subframe_tick = sf; frame_tick = fr; ball_vel_load = ld;
    ball_vx_in = 9'(bvx); ball_vy_in = 9'(bvy); paddle_vel = 8'(pv);
    if (fr) begin
      mox = mbx >>> 8; moy = mby >>> 8; mop = mpad;
      mpad = pad_step(mpad, pv);
    end
    if (sf) begin
      axis_step(mbx, mvx, XMAX);
      axis_step(mby, mvy, YMAX);
    end
    if (ld) begin mvx = sat_load(bvx); mvy = sat_load(bvy); end
    @(posedge clk); #1;
    subframe_tick = 0; frame_tick = 0; ball_vel_load = 0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    bvx = 0; bvy = 0; pv = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 check("R1 reset");
    @(negedge clk) rst = 0;
    step(0, 1, 0, "R1 after reset");

    // R6: load with a same-cycle step that still uses the zero velocity
    bvx = 100; bvy = -50;
    step(1, 0, 1, "R6 load");
    step(0, 1, 0, "R6 old velocity used");
    // R2: ten steps, fraction carries into the pixel part
    for (int i = 0; i < 10; i++) step(1, 0, 0, "R2 step");
    step(0, 1, 0, "R2 after ten steps");
    // R5: idle cycles and frame ticks only
    for (int i = 0; i < 5; i++) step(0, 0, 0, "R5 idle");
    step(0, 1, 0, "R5 unchanged");
    // R3: full speed toward left and top edges
    bvx = -255; bvy = -255;
    step(0, 0, 1, "R6 load negative");
    for (int i = 0; i < 400; i++) step(1, 1, 0, "R3 R10 low edge bounce");
    // R4: toward right and bottom edges
    bvx = 255; bvy = 255;
    step(0, 0, 1, "R6 load positive");
    for (int i = 0; i < 800; i++) step(1, (i % 3) == 0, 0, "R4 high edge bounce");
    // R6: -256 code saturates
    bvx = -256; bvy = -256;
    step(0, 0, 1, "R6 min code");
    for (int i = 0; i < 300; i++) step(1, 1, 0, "R6 R3 min code motion");
    // R7: paddle past both limits
    pv = 127;
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R7 paddle top limit");
    pv = -128;
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R7 paddle zero limit");
    pv = 100;
    for (int i = 0; i < 20; i++) step(1, 0, 0, "R8 no frame tick");
    step(0, 1, 0, "R8 paddle held");
    step(0, 1, 0, "R7 paddle moved");

    // Random frames: 256 subframes each, frame tick on the last one
    for (int f = 0; f < 50; f++) begin
      pv = int'($urandom_range(0, 255)) - 128;
      for (int s = 0; s < 256; s++) begin
        bit ld;
        ld = ($urandom_range(0, 63) == 0);
        if (ld) begin
          bvx = int'($urandom_range(0, 511)) - 256;
          bvy = int'($urandom_range(0, 511)) - 256;
        end
        if ($urandom_range(0, 3) == 0) step(0, 0, 0, "R5 random gap");
        step(1, s == 255, ld, "R2 R3 R4 R9 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule